// File: doc/BRIEF.md
# Audio master clock divider

This block derives an audio master clock from a divider reference. A 3-bit rate code selects a power-of-two division, and one base select input names the family of the root clock. With base select 0 the root runs at 512·fs, and the codes 0 to 4 give 512, 256, 128, 64 and 32 times fs. With base select 1 the root runs at 384·fs, and the codes 0 to 3 give 384, 192, 96 and 48 times fs. The same code therefore means a different ratio in each family. The output comes from a registered flop, so the block runs on a reference clock `refClk` at twice the root rate. One root cycle is two `refClk` cycles, and code N gives an output period of 2^(N+1) `refClk` cycles with a 50% duty cycle.

The output runs only while `runEn` is high, which stands for "running and not clock-gated", and only while the configuration is legal. Starting, stopping and changing the code take effect only at the end of a high half-period. The output therefore never shows a pulse shorter than a full half-period.

Top module: `mclk_div_top`

## Requirements
- R1: After reset, `mclkOut` and `cfgIllegal` are both 0.
- R2: With `baseSel`=0, `runEn`=1 and `rateCode` N in 0..4, `mclkOut` settles to a period of 2^(N+1) `refClk` cycles, with high runs of exactly 2^N cycles.
- R3: With `baseSel`=1, `runEn`=1 and `rateCode` N in 0..3, `mclkOut` settles to a period of 2^(N+1) cycles, with high runs of exactly 2^N cycles.
- R4: The configuration is illegal when `rateCode` is above 4 with `baseSel`=0, or above 3 with `baseSel`=1. While it is illegal, the output finishes its current high half-period and then stays low.
- R5: When `runEn` falls while the output is running, the output finishes its current high half-period and then stays low. No high run is cut short.
- R6: On a start, the output first spends a full low half-period low before its first full-length high run.
- R7: When a legal code changes while the output runs, the output stops at the end of the current high half-period. It restarts with the new period only after a full low half-period of the new code.
- R8: `cfgIllegal` reflects the legality of the inputs with one cycle of latency: it is set on the first edge after an illegal code is applied and cleared on the first edge after a legal one.
- R9: The output follows a cycle-exact schedule set by a free-running counter that starts at 0 after reset. This counter decides where every period boundary falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Divider reference, twice the root clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| baseSel | input | 1 | Root family: 0 selects 512·fs, 1 selects 384·fs |
| rateCode | input | 3 | Power-of-two division code |
| runEn | input | 1 | High when running and not clock-gated |
| mclkOut | output | 1 | Master clock output |
| cfgIllegal | output | 1 | Registered flag for an unsupported code/base pair |

## Verification
Every output is registered. A change of inputs applied before an edge is visible on `cfgIllegal` right after that edge. The same change reaches `mclkOut` only at the edge that closes the current high half-period, which for code N can be up to 2^(N+1) cycles later. The bench drives inputs on falling edges and updates a behavioural model on each rising edge from those inputs. It compares both outputs on the next falling edge, so each expected value is taken one edge after the inputs that produce it. Pulse-width checks wait for a rising edge of the output and then count the high samples, so they measure only fully settled periods.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic              runNext;
    logic [CODE_W-1:0] codeNext;
  } divStrobe_t;
endpackage

// File: rtl/mclk_cfg_decode.sv
module mclk_cfg_decode #(
  parameter int CODE_W   = 3,
  parameter int MAX_FULL = 4,
  parameter int MAX_ALT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseSel,
  input  logic [CODE_W-1:0] rateCode,
  output logic              cfgLegal,
  output logic              cfgIllegalQ
);
  localparam logic [CODE_W-1:0] LIM_FULL = CODE_W'(MAX_FULL);
  localparam logic [CODE_W-1:0] LIM_ALT  = CODE_W'(MAX_ALT);

  always_comb begin
    if (baseSel) cfgLegal = (rateCode <= LIM_ALT);
    else         cfgLegal = (rateCode <= LIM_FULL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgIllegalQ <= 1'b0;
    else       cfgIllegalQ <= ~cfgLegal;
  end

  // R8: flag follows the inputs one edge later
  p_flag_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cfgIllegalQ == $past(~cfgLegal)));
endmodule

// File: rtl/mclk_div_ctrl.sv
module mclk_div_ctrl
  import mclk_div_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int MAX_FULL = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              cfgLegal,
  input  logic [CODE_W-1:0] rateCode,
  input  logic [CNT_W-1:0]  cnt,
  output divStrobe_t        strobe,
  output logic              runQ
);
  logic [CODE_W-1:0] codeQ;
  logic [CODE_W-1:0] candCode;
  logic              endCur;
  logic              endCand;

  // high when the counter bits up to the selected tap are all ones
  function automatic logic atPeriodEnd(input logic [CNT_W-1:0] c,
                                       input logic [CODE_W-1:0] code);
    logic r;
    r = 1'b1;
    for (int i = 0; i < CNT_W; i++) begin
      if ((i <= int'(code)) && !c[i]) r = 1'b0;
    end
    return r;
  endfunction

  always_comb begin
    candCode = cfgLegal ? rateCode : codeQ;
    endCur   = atPeriodEnd(cnt, codeQ);
    endCand  = atPeriodEnd(cnt, candCode);
    strobe.runNext  = runQ;
    strobe.codeNext = codeQ;
    if (!runQ) begin
      strobe.codeNext = candCode;
      strobe.runNext  = runEn && cfgLegal && endCand;
    end else if (endCur) begin
      strobe.codeNext = candCode;
      strobe.runNext  = runEn && cfgLegal && (rateCode == codeQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      codeQ <= '0;
    end else begin
      runQ  <= strobe.runNext;
      codeQ <= strobe.codeNext;
    end
  end

  // R7: the active code never moves while the output keeps running
  p_code_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && $past(runQ)) |-> $stable(codeQ));
  // R4: the held code stays within the widest legal range
  p_code_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    int'(codeQ) <= MAX_FULL);
endmodule

// File: rtl/mclk_div_datapath.sv
module mclk_div_datapath
  import mclk_div_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic             runQ,
  output logic [CNT_W-1:0] cnt,
  output logic             mclkQ
);
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] tapHit;
  logic             tap;

  assign cntNext = cnt + 1'b1;

  for (genvar g = 0; g < CNT_W; g++) begin : g_tap
    assign tapHit[g] = (int'(strobe.codeNext) == g) && cntNext[g];
  end
  assign tap = |tapHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      mclkQ <= 1'b0;
    end else begin
      cnt   <= cntNext;
      mclkQ <= strobe.runNext & tap;
    end
  end

  // R5: output is low whenever the controller is idle
  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !mclkQ);
  // R6: a start always begins in the low half
  p_start_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> !mclkQ);
  // R5: a stop only follows the last cycle of a high half
  p_stop_after_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runQ) |-> $past(mclkQ));
endmodule

// File: rtl/mclk_div_top.sv
module mclk_div_top
  import mclk_div_pkg::*;
#(
  parameter int MAX_FULL = 4,
  parameter int MAX_ALT  = 3
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              baseSel,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              runEn,
  output logic              mclkOut,
  output logic              cfgIllegal
);
  localparam int CNT_W = MAX_FULL + 1;

  logic             cfgLegal;
  logic             runQ;
  logic [CNT_W-1:0] cnt;
  divStrobe_t       strobe;

  mclk_cfg_decode #(.CODE_W(CODE_W), .MAX_FULL(MAX_FULL), .MAX_ALT(MAX_ALT)) u_dec (
    .clk(refClk), .rstN(rstN), .baseSel(baseSel), .rateCode(rateCode),
    .cfgLegal(cfgLegal), .cfgIllegalQ(cfgIllegal)
  );

  mclk_div_ctrl #(.CNT_W(CNT_W), .MAX_FULL(MAX_FULL)) u_ctrl (
    .clk(refClk), .rstN(rstN), .runEn(runEn), .cfgLegal(cfgLegal),
    .rateCode(rateCode), .cnt(cnt), .strobe(strobe), .runQ(runQ)
  );

  mclk_div_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(refClk), .rstN(rstN), .strobe(strobe), .runQ(runQ),
    .cnt(cnt), .mclkQ(mclkOut)
  );

  // R4: no start while the flag reports an illegal pair
  p_no_start_illegal_r4: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(runQ) |-> !cfgIllegal);
endmodule

// File: tb/mclk_div_top_tb_top.sv
`timescale 1ns/1ps
module mclk_div_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseSel = 1'b0;
  logic [2:0] rateCode = 3'd0;
  logic       runEn = 1'b0;
  logic       mclkOut, cfgIllegal;

  int errors = 0;
  int checks = 0;
  string curReq = "R9";

  always #2.5 clk = ~clk;

  mclk_div_top dut_i (
    .refClk(clk), .rstN(rstN), .baseSel(baseSel), .rateCode(rateCode),
    .runEn(runEn), .mclkOut(mclkOut), .cfgIllegal(cfgIllegal)
  );

  // behavioural reference: tick count modulo 32, period bookkeeping
  int  mTick = 0;
  bit  mRun = 0;
  int  mCode = 0;
  bit  mOut = 0;
  bit  mIll = 0;

  function automatic bit lastOfPeriod(int t, int code);
    return ((t + 1) % (1 << (code + 1))) == 0;
  endfunction

  always @(posedge clk) begin
    int  code;
    bit  legal;
    bit  nRun;
    int  nCode;
    if (!rstN) begin
      mTick = 0; mRun = 0; mCode = 0; mOut = 0; mIll = 0;
    end else begin
      code  = int'(rateCode);
      legal = baseSel ? (code <= 3) : (code <= 4);
      nRun  = mRun;
      nCode = mCode;
      if (!mRun) begin
        nCode = legal ? code : mCode;
        nRun  = runEn && legal && lastOfPeriod(mTick, nCode);
      end else if (lastOfPeriod(mTick, mCode)) begin
        nCode = legal ? code : mCode;
        nRun  = runEn && legal && (code == mCode);
      end
      mTick = (mTick + 1) % 32;
      mRun  = nRun;
      mCode = nCode;
      mOut  = nRun && (((mTick >> nCode) & 1) == 1);
      mIll  = !legal;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (mclkOut !== mOut) begin
        errors++;
        $display("FAIL %s R9: mclkOut=%0b expected %0b at %0t", curReq, mclkOut, mOut, $time);
      end
      checks++;
      if (cfgIllegal !== mIll) begin
        errors++;
        $display("FAIL R8: cfgIllegal=%0b expected %0b at %0t", cfgIllegal, mIll, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for a rising output, then count high samples
  task automatic measureHigh(input string req, input int exp);
    int guard;
    int len;
    guard = 0;
    while (mclkOut !== 1'b0 && guard < 300) begin @(negedge clk); guard++; end
    while (mclkOut !== 1'b1 && guard < 300) begin @(negedge clk); guard++; end
    len = 0;
    while (mclkOut === 1'b1 && guard < 300) begin len++; @(negedge clk); guard++; end
    check(req, len, exp);
  endtask

  task automatic countHigh(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mclkOut === 1'b1) highs++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int highs;
    repeat (4) @(negedge clk);
    checks++;
    if (mclkOut !== 1'b0 || cfgIllegal !== 1'b0) begin
      errors++;
      $display("FAIL R1: mclkOut=%0b cfgIllegal=%0b expected 0 0", mclkOut, cfgIllegal);
    end
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(mclkOut), 0);

    // R2: 512 family
    for (int c = 0; c <= 4; c++) begin
      curReq = "R2";
      runEn = 1'b0; baseSel = 1'b0; rateCode = 3'(c);
      repeat (70) @(negedge clk);
      curReq = "R6";
      runEn = 1'b1;
      repeat (2) @(negedge clk);
      curReq = "R2";
      measureHigh("R2", 1 << c);
      measureHigh("R2", 1 << c);
    end

    // R3: 384 family
    for (int c = 0; c <= 3; c++) begin
      curReq = "R3";
      runEn = 1'b0; baseSel = 1'b1; rateCode = 3'(c);
      repeat (70) @(negedge clk);
      runEn = 1'b1;
      measureHigh("R3", 1 << c);
      measureHigh("R3", 1 << c);
    end

    // R5: stop in mid high half
    curReq = "R5";
    baseSel = 1'b0; rateCode = 3'd3;
    repeat (40) @(negedge clk);
    while (mclkOut !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    runEn = 1'b0;
    repeat (20) @(negedge clk);
    countHigh(40, highs);
    check("R5", highs, 0);

    // R7: code change while running
    curReq = "R7";
    runEn = 1'b1; rateCode = 3'd1;
    repeat (30) @(negedge clk);
    while (mclkOut !== 1'b1) @(negedge clk);
    rateCode = 3'd4;
    repeat (40) @(negedge clk);
    measureHigh("R7", 16);
    rateCode = 3'd0;
    repeat (40) @(negedge clk);
    measureHigh("R7", 1);

    // R4/R8: code 4 in the 384 family
    curReq = "R4";
    baseSel = 1'b1; rateCode = 3'd2;
    repeat (30) @(negedge clk);
    rateCode = 3'd4;
    @(negedge clk);
    check("R8", int'(cfgIllegal), 1);
    repeat (20) @(negedge clk);
    countHigh(40, highs);
    check("R4", highs, 0);
    baseSel = 1'b0; rateCode = 3'd6;
    @(negedge clk);
    check("R4", int'(cfgIllegal), 1);
    countHigh(40, highs);
    check("R4", highs, 0);
    rateCode = 3'd2;
    @(negedge clk);
    check("R8", int'(cfgIllegal), 0);
    curReq = "R6";
    measureHigh("R6", 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule